// File: doc/BRIEF.md
# External Memory Write Sequencer with Wait-State Modes

This block is a bus-master write sequencer for asynchronous external memories and memory-mapped peripherals. An internal client presents one write at a time: an address, a data word and a configuration word. The configuration word selects one of four wait-state modes, a 3-bit wait-state count, an optional address hold cycle and an optional bus idle cycle. The sequencer then drives the address, an active-low memory select, an active-low write strobe and the write data with its output enable. It ends with a one-clock completion pulse. All timing is counted in whole core clock cycles.

The strobe length depends on the mode. The programmed count can set it, a slave acknowledge input can set it, or both can set it together. This lets fast devices run with a fixed count while slow slaves stretch the access. The configuration is captured when a request is accepted, so it may change freely while an access is in flight.

States: `ST_IDLE` (ready, bus released), `ST_SETUP` (address and select driven, strobe high), `ST_STROBE` (strobe low, data driven), `ST_HOLD` (strobe high, address, select and data still driven), `ST_BUSIDLE` (bus released, no completion yet), `ST_DONE` (completion pulse). Transitions: IDLE→SETUP on an accepted request; SETUP→STROBE always; STROBE→STROBE until the mode's end condition holds; STROBE→HOLD when hold is enabled; STROBE→BUSIDLE when idle is enabled and hold is not; STROBE→DONE when neither is enabled; HOLD→BUSIDLE when idle is enabled; HOLD→DONE otherwise; BUSIDLE→DONE always; DONE→IDLE always.

Top module: `ext_wr_ctrl`

## Requirements
- R1: After reset, `req_ready`=1, `mem_sel_n`=1, `mem_wr_n`=1, `mem_data_oe`=0 and `done`=0.
- R2: An accepted request (`req_valid` high while `req_ready` is high at a clock edge) is followed by exactly one cycle with `mem_sel_n`=0 and `mem_wr_n`=1 before `mem_wr_n` falls. `mem_wr_n` is never low while `mem_sel_n` is high, and `mem_addr` equals the request address while `mem_sel_n` is low.
- R3: Mode 2'b01 (count only): `mem_wr_n` stays low for exactly count+1 cycles, and `mem_ack` has no effect on that length.
- R4: Mode 2'b00 (acknowledge only): `mem_wr_n` stays low up to and including the first strobe cycle whose closing clock edge samples `mem_ack` high. The count has no effect.
- R5: Mode 2'b11 (first of the two): the strobe ends at the first strobe cycle that either samples `mem_ack` high or is cycle count+1, whichever comes first.
- R6: Mode 2'b10 (both required): the strobe ends at the first strobe cycle that is at or beyond cycle count+1 and samples `mem_ack` high. With a count of zero, acknowledge ends it on the first cycle.
- R7: `mem_data_oe` is high during every strobe-low cycle and during the hold cycle, and low otherwise. While it is high, `mem_data_out` equals the request data.
- R8: With hold enabled (configuration bit 1), `mem_sel_n` and `mem_addr` stay driven for exactly one cycle after `mem_wr_n` rises. With hold disabled, `mem_sel_n` rises together with `mem_wr_n`.
- R9: With idle enabled (configuration bit 0), exactly one cycle with nothing driven is inserted between the end of the strobe or hold cycle and `done`. With idle disabled, there is none.
- R10: `done` is high for exactly one cycle after the last strobe, hold or idle cycle. `req_ready` is low from acceptance through that cycle and high in the cycle after it.
- R11: Mode, count, hold and idle are captured at acceptance. Changes on the configuration inputs during an access do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| cfg_mode | input | 2 | Wait mode: 00 ack only, 01 count only, 10 both, 11 either |
| cfg_ws | input | WS_W | Wait-state count |
| cfg_hold_en | input | 1 | Insert address hold cycle |
| cfg_idle_en | input | 1 | Insert bus idle cycle |
| req_ready | output | 1 | Request accepted when high with req_valid |
| done | output | 1 | One-cycle completion pulse |
| mem_ack | input | 1 | Slave acknowledge |
| mem_addr | output | ADDR_W | Memory address (zero when not selected) |
| mem_sel_n | output | 1 | Active-low memory select |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_data_out | output | DATA_W | Write data (zero when not enabled) |
| mem_data_oe | output | 1 | Data bus output enable |

## Verification
The bench builds the block with its defaults: 16-bit address and data and a 3-bit count. The full count range 0 to 7 is therefore reachable, including the largest count, where the wait counter saturates against its own limit. The bench sets acknowledge to arrive before, exactly at, and after the count expiry, so each mode's end rule is seen on both sides of the boundary. It also scrambles the configuration inputs during every access, so that capture at acceptance is exercised.

// File: rtl/ext_wr_pkg.sv
package ext_wr_pkg;

    typedef enum logic [1:0] {
        WM_ACK    = 2'b00,
        WM_COUNT  = 2'b01,
        WM_BOTH   = 2'b10,
        WM_EITHER = 2'b11
    } wait_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_BUSIDLE,
        ST_DONE
    } wr_state_e;

endpackage

// File: rtl/ext_wr_capture.sv
module ext_wr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/ext_wr_waitcnt.sv
module ext_wr_waitcnt #(
    parameter int WS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [WS_W-1:0] limit,
    output logic            reached
);
    logic [WS_W-1:0] cnt_q;

    assign reached = (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!reached) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ext_wr_term.sv
module ext_wr_term
    import ext_wr_pkg::*;
(
    input  wait_mode_e mode,
    input  logic       count_done,
    input  logic       ack,
    output logic       strobe_end
);
    always_comb begin
        unique case (mode)
            WM_ACK:    strobe_end = ack;
            WM_COUNT:  strobe_end = count_done;
            WM_BOTH:   strobe_end = count_done & ack;
            WM_EITHER: strobe_end = count_done | ack;
            default:   strobe_end = 1'b1;
        endcase
    end
endmodule

// File: rtl/ext_wr_ctrl.sv
module ext_wr_ctrl
    import ext_wr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int WS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        cfg_mode,
    input  logic [WS_W-1:0]   cfg_ws,
    input  logic              cfg_hold_en,
    input  logic              cfg_idle_en,
    output logic              req_ready,
    output logic              done,
    input  logic              mem_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_wr_n,
    output logic [DATA_W-1:0] mem_data_out,
    output logic              mem_data_oe
);
    localparam int CFG_W = 2 + WS_W + 2;
    localparam int REQ_W = ADDR_W + DATA_W;

    wr_state_e state_q, state_d;

    logic              accept;
    logic [CFG_W-1:0]  cfg_q;
    logic [REQ_W-1:0]  req_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    wait_mode_e        mode_q;
    logic [WS_W-1:0]   ws_q;
    logic              hold_q, idle_q;
    logic              in_strobe, count_done, strobe_end;

    assign accept = (state_q == ST_IDLE) && req_valid;

    ext_wr_capture #(.W(CFG_W)) cfg_cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .d     ({cfg_mode, cfg_ws, cfg_hold_en, cfg_idle_en}),
        .q     (cfg_q)
    );

    ext_wr_capture #(.W(REQ_W)) req_cap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .d     ({req_addr, req_data}),
        .q     (req_q)
    );

    assign mode_q = wait_mode_e'(cfg_q[CFG_W-1 -: 2]);
    assign ws_q   = cfg_q[2 +: WS_W];
    assign hold_q = cfg_q[1];
    assign idle_q = cfg_q[0];
    assign addr_q = req_q[REQ_W-1 -: ADDR_W];
    assign data_q = req_q[DATA_W-1:0];

    assign in_strobe = (state_q == ST_STROBE);

    ext_wr_waitcnt #(.WS_W(WS_W)) wcnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_strobe),
        .limit   (ws_q),
        .reached (count_done)
    );

    ext_wr_term term_i (
        .mode       (mode_q),
        .count_done (count_done),
        .ack        (mem_ack),
        .strobe_end (strobe_end)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_SETUP;
            ST_SETUP:   state_d = ST_STROBE;
            ST_STROBE: begin
                if (strobe_end) begin
                    if (hold_q)      state_d = ST_HOLD;
                    else if (idle_q) state_d = ST_BUSIDLE;
                    else             state_d = ST_DONE;
                end
            end
            ST_HOLD:    state_d = idle_q ? ST_BUSIDLE : ST_DONE;
            ST_BUSIDLE: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        done         = 1'b0;
        mem_sel_n    = 1'b1;
        mem_wr_n     = 1'b1;
        mem_data_oe  = 1'b0;
        mem_addr     = '0;
        mem_data_out = '0;
        unique case (state_q)
            ST_IDLE:    req_ready = 1'b1;
            ST_SETUP: begin
                mem_sel_n = 1'b0;
                mem_addr  = addr_q;
            end
            ST_STROBE: begin
                mem_sel_n    = 1'b0;
                mem_wr_n     = 1'b0;
                mem_addr     = addr_q;
                mem_data_oe  = 1'b1;
                mem_data_out = data_q;
            end
            ST_HOLD: begin
                mem_sel_n    = 1'b0;
                mem_addr     = addr_q;
                mem_data_oe  = 1'b1;
                mem_data_out = data_q;
            end
            ST_BUSIDLE: ;
            ST_DONE:    done = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/ext_wr_ctrl_chk.sv
module ext_wr_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              mem_sel_n,
    input logic              mem_wr_n,
    input logic              mem_data_oe,
    input logic [DATA_W-1:0] mem_data_out
);
    AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> !mem_sel_n); // R2

    AST_SEL_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wr_n) |-> $past(!mem_sel_n && mem_wr_n)); // R2

    AST_STROBE_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> mem_data_oe); // R7

    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_data_oe && $past(mem_data_oe)) |-> $stable(mem_data_out)); // R7

    AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_wr_n) && !mem_sel_n) |=> mem_sel_n); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready)); // R10

    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!req_ready && mem_sel_n && !mem_data_oe)); // R10
endmodule

bind ext_wr_ctrl ext_wr_ctrl_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/ext_wr_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_wr_ctrl_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int WS_W   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [1:0]        cfg_mode = '0;
    logic [WS_W-1:0]   cfg_ws = '0;
    logic              cfg_hold_en = 1'b0;
    logic              cfg_idle_en = 1'b0;
    logic              req_ready, done, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_sel_n, mem_wr_n, mem_data_oe;
    logic [DATA_W-1:0] mem_data_out;

    always #5 clk = ~clk;

    ext_wr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .cfg_mode(cfg_mode), .cfg_ws(cfg_ws),
        .cfg_hold_en(cfg_hold_en), .cfg_idle_en(cfg_idle_en),
        .req_ready(req_ready), .done(done), .mem_ack(mem_ack),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_wr_n(mem_wr_n),
        .mem_data_out(mem_data_out), .mem_data_oe(mem_data_oe)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        int strobe;
        int hold;
        int idle;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    int ack_at   = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // acknowledge driver: high from strobe cycle ack_at onward (0 = never)
    int strobe_j = 0;
    logic ack_r = 1'b0;
    assign mem_ack = ack_r;
    always @(negedge clk) begin
        if (!mem_wr_n) begin
            strobe_j++;
            ack_r = (ack_at != 0) && (strobe_j >= ack_at);
        end else begin
            strobe_j = 0;
            ack_r = 1'b0;
        end
    end

    // monitor / scoreboard
    bit   in_txn = 0, seen_str = 0, prev_done = 0, bad_addr = 0, bad_data = 0;
    int   c_setup, c_strobe, c_hold, c_idle, c_oe;
    exp_t cur;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_done)
                chk(!done && req_ready, "R10", "ready after done pulse",
                    {done, req_ready}, 1);
            prev_done = done;
            if (!in_txn && !mem_sel_n) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected access", 1, 0);
                end else begin
                    cur = exp_q[0];
                end
                in_txn = 1; seen_str = 0; bad_addr = 0; bad_data = 0;
                c_setup = 0; c_strobe = 0; c_hold = 0; c_idle = 0; c_oe = 0;
            end
            if (in_txn) begin
                if (req_ready) chk(0, "R10", "ready during access", 1, 0);
                if (!mem_sel_n && mem_wr_n && !seen_str) c_setup++;
                if (!mem_wr_n) begin c_strobe++; seen_str = 1; end
                if (!mem_sel_n && mem_wr_n && seen_str) c_hold++;
                if (!mem_sel_n && mem_addr !== cur.addr) bad_addr = 1;
                if (mem_data_oe) begin
                    c_oe++;
                    if (mem_data_out !== cur.data) bad_data = 1;
                end
                if (seen_str && mem_sel_n && !done) c_idle++;
                if (done) begin
                    void'(exp_q.pop_front());
                    chk(c_setup == 1, "R2", "setup cycles", c_setup, 1);
                    chk(!bad_addr, "R2", "address while selected", bad_addr, 0);
                    chk(c_strobe == cur.strobe, cur.req, "strobe length",
                        c_strobe, cur.strobe);
                    chk(c_hold == cur.hold, "R8", "hold cycles", c_hold, cur.hold);
                    chk(c_idle == cur.idle, "R9", "idle cycles", c_idle, cur.idle);
                    chk(c_oe == cur.strobe + cur.hold, "R7", "data enable cycles",
                        c_oe, cur.strobe + cur.hold);
                    chk(!bad_data, "R7", "data value", bad_data, 0);
                    in_txn = 0;
                end
            end else if (done) begin
                chk(0, "R10", "done outside access", 1, 0);
            end
        end
    end

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                            input logic [1:0] mode, input int ws, input bit hold,
                            input bit idle, input int ackat, input string req);
        exp_t e;
        int lim;
        lim = ws + 1;
        e.addr = a; e.data = d; e.req = req;
        e.hold = hold ? 1 : 0;
        e.idle = idle ? 1 : 0;
        unique case (mode)
            2'b01: e.strobe = lim;
            2'b00: e.strobe = ackat;
            2'b11: e.strobe = (ackat == 0 || ackat > lim) ? lim : ackat;
            default: e.strobe = (ackat > lim) ? ackat : lim;
        endcase
        exp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d;
        cfg_mode = mode; cfg_ws = WS_W'(ws); cfg_hold_en = hold; cfg_idle_en = idle;
        ack_at = ackat;
        @(negedge clk);
        req_valid = 1'b0;
        // R11: scramble configuration and request inputs during the access
        cfg_mode = ~mode; cfg_ws = ~WS_W'(ws); cfg_hold_en = ~hold;
        cfg_idle_en = ~idle; req_addr = ~a; req_data = ~d;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        #1;
        chk(req_ready && mem_sel_n && mem_wr_n && !mem_data_oe && !done, "R1",
            "state in reset", {req_ready, mem_sel_n, mem_wr_n, mem_data_oe, done}, 5'b11100);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_sel_n && mem_wr_n && !mem_data_oe && !done, "R1",
            "state after reset", {req_ready, mem_sel_n, mem_wr_n, mem_data_oe, done}, 5'b11100);

        do_write(16'h1000, 16'hA5A5, 2'b01, 0, 0, 0, 0, "R3");
        do_write(16'h1002, 16'h5A5A, 2'b01, 3, 0, 0, 1, "R3");
        do_write(16'h1004, 16'h0F0F, 2'b01, 7, 1, 0, 0, "R3");
        do_write(16'h2000, 16'hF0F0, 2'b00, 7, 0, 0, 2, "R4");
        do_write(16'h2002, 16'h1234, 2'b00, 0, 0, 1, 5, "R4");
        do_write(16'h3000, 16'h4321, 2'b11, 5, 0, 0, 2, "R5");
        do_write(16'h3002, 16'hBEEF, 2'b11, 2, 0, 0, 0, "R5");
        do_write(16'h3004, 16'hCAFE, 2'b11, 2, 1, 1, 6, "R5");
        do_write(16'h4000, 16'h0001, 2'b10, 0, 0, 0, 1, "R6");
        do_write(16'h4002, 16'h8000, 2'b10, 3, 0, 1, 1, "R6");
        do_write(16'h4004, 16'h7FFE, 2'b10, 2, 1, 1, 6, "R6");
        do_write(16'h5000, 16'hFFFF, 2'b01, 1, 1, 1, 0, "R11");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule